// File: doc/BRIEF.md
# Buck converter mode and startup sequencer

This block is the digital sequencer of a synchronous step-down converter. It decides when the high-side and low-side switches may operate, and in which regime, from power-up to steady state. The analog side supplies digitised comparator results: feedback above the soft-start voltage, feedback above the power-good level, inductor current near zero, and a per-period flag that says whether the high side stayed idle. A tick marks each switching period. Apart from the enable drop and the zero-cross response, every decision is taken on a tick.

Three regimes are supported. Code 00 gives plain forced PWM, and switching starts at once. Code 01 gives forced PWM with monotonic startup. Codes 10 and 11 give skip mode with monotonic startup. In the monotonic variants both switches stay off until the feedback reaches the soft-start voltage. This keeps a prebiased output from being pulled down. Every start opens with one low-side period that charges the bootstrap capacitor. The low-side sink limit then climbs through four codes. The chosen regime takes over only after a long confirmation window that follows power-good. In skip mode the low side is released at zero current. A bootstrap refresh pulse is placed ahead of the first high-side period after a long idle run.

Top module: `buck_sequencer`

## Requirements
- R1: The regime output uses the encoding 0 off, 1 forced PWM, 2 monotonic startup, 3 skip. During startup, mode code 00 reports 1, code 01 reports 2, and codes 10 and 11 report 2. After startup, code 00 or 01 reports 1 and code 10 or 11 reports 3.
- R2: With mode code 01, 10 or 11, both switch requests stay low after enable until a tick on which fb_above_ss is high.
- R3: The first switching period after a start has ls_en high and hs_en low. hs_en never rises unless ls_en was high in the cycle before.
- R4: With mode code 00, switching starts on the first tick after enable, whatever the feedback flags.
- R5: sink_code is 0 when a start begins. It advances by one every 32 ticks counted from the low-side precharge period and holds at 3.
- R6: Startup ends 4096 ticks after the first tick on which fb_good is seen. Until then the regime stays 2 and skip behaviour is not applied, even when skip is selected.
- R7: In the final forced PWM regime both requests are high and the zero-cross flag has no effect.
- R8: In skip mode hs_en is high, and ls_en goes low one cycle after izero goes high.
- R9: In skip mode, after more than 8 consecutive ticks with hs_idle high, the next tick with hs_idle low produces one period with hs_en low and ls_en high. A run of 8 or fewer idle ticks produces no such period.
- R10: After startup, a change of mode code between skip and forced PWM takes effect on the next clock edge.
- R11: With en low, all outputs are zero from the next clock edge. A later enable restarts the whole sequence, with the sink ramp counting from 0.
- R12: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| tick | input | 1 | One-cycle pulse per switching period |
| mode_code | input | 2 | Decoded regime selection (00 plain PWM, 01 monotonic PWM, 1x skip) |
| fb_above_ss | input | 1 | Feedback above soft-start voltage |
| fb_good | input | 1 | Feedback above the power-good level |
| izero | input | 1 | Inductor current near zero |
| hs_idle | input | 1 | High side did not switch this period |
| hs_en | output | 1 | High-side switch request |
| ls_en | output | 1 | Low-side switch request |
| regime | output | 2 | Active regime |
| sink_code | output | 2 | Low-side sink-current limit step |

## Verification
The embedded assertions watch, on every cycle, the properties that can be checked locally. The high side never rises without a low-side period before it. The hold is released only by a tick with the soft-start flag set. Handover to the final regime happens only on the timer's done pulse. The sink code never falls or jumps during a run. A refresh pulse lasts one period. An enable drop clears the outputs. The bench scenarios are what show the counted windows: the 32-tick sink steps, the 4096-tick handover with skip held off, the difference between 8 and 9 idle ticks for the refresh, the live mode switch after startup, and the full restart after a disable.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_HOLD   = 3'd1,
    ST_PRECHG = 3'd2,
    ST_START  = 3'd3,
    ST_FINAL  = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    RG_OFF  = 2'd0,
    RG_PWM  = 2'd1,
    RG_MONO = 2'd2,
    RG_SKIP = 2'd3
  } regime_t;

  localparam logic [1:0] MODE_PLAIN = 2'b00;

  function automatic logic mode_is_skip(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/bsq_phase_fsm.sv
module bsq_phase_fsm
  import buck_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic [1:0] mode_code,
  input  logic       fb_above_ss,
  input  logic       handover_done,
  output seq_state_t state,
  output logic [1:0] start_mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      start_mode <= MODE_PLAIN;
    end else if (!en) begin
      state <= ST_OFF;
    end else if (tick) begin
      case (state)
        ST_OFF: begin
          start_mode <= mode_code;
          state      <= (mode_code == MODE_PLAIN) ? ST_PRECHG : ST_HOLD;
        end
        ST_HOLD:   if (fb_above_ss) state <= ST_PRECHG;
        ST_PRECHG: state <= (start_mode == MODE_PLAIN) ? ST_FINAL : ST_START;
        ST_START:  if (handover_done) state <= ST_FINAL;
        ST_FINAL:  state <= ST_FINAL;
        default:   state <= ST_OFF;
      endcase
    end
  end

  // R2: the hold is left only on a tick that saw the soft-start flag
  assert_hold_release_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRECHG && $past(state) == ST_HOLD) |-> $past(fb_above_ss && tick));

  // R6: the final regime is entered from startup only on the timer's done pulse
  assert_handover_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINAL && $past(state) == ST_START) |-> $past(handover_done));

endmodule

// File: rtl/bsq_sink_ramp.sv
module bsq_sink_ramp #(
  parameter int STEP_TICKS = 32,
  parameter int NUM_STEPS  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic                         tick,
  output logic [$clog2(NUM_STEPS)-1:0] code
);

  localparam int CODE_W = $clog2(NUM_STEPS);
  localparam int SUB_W  = $clog2(STEP_TICKS);
  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(NUM_STEPS - 1);
  localparam logic [SUB_W-1:0]  SUB_LAST = SUB_W'(STEP_TICKS - 1);

  logic [SUB_W-1:0] sub_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sub_cnt <= '0;
      code    <= '0;
    end else if (tick && code != CODE_MAX) begin
      if (sub_cnt == SUB_LAST) begin
        sub_cnt <= '0;
        code    <= code + 1'b1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end
  end

  // R5: during a run the sink code never falls
  assert_ramp_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (code >= $past(code)));

  // R5: during a run the sink code moves by one step at most
  assert_ramp_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && code != $past(code)) |-> (code == CODE_W'($past(code) + 1'b1)));

endmodule

// File: rtl/bsq_handover.sv
module bsq_handover #(
  parameter int HOLD_TICKS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  input  logic fb_good,
  output logic done
);

  localparam int CNT_W = $clog2(HOLD_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  logic             seen;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      seen <= 1'b0;
      cnt  <= '0;
    end else if (tick) begin
      if (!seen) seen <= fb_good;
      else       cnt  <= cnt + 1'b1;
    end
  end

  assign done = active && tick && seen && (cnt == CNT_LAST);

  // R6: once power-good has been seen in startup it stays latched
  assert_seen_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && $past(seen)) |-> seen);

  // R6: the window counter stays at zero until power-good is seen
  assert_count_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (cnt == '0));

endmodule

// File: rtl/bsq_skip_refresh.sv
module bsq_skip_refresh #(
  parameter int IDLE_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic tick,
  input  logic hs_idle,
  output logic refresh
);

  localparam int IDLE_W = $clog2(IDLE_LIMIT + 2);
  localparam logic [IDLE_W-1:0] IDLE_SAT = IDLE_W'(IDLE_LIMIT + 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(IDLE_LIMIT);

  logic [IDLE_W-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      idle_cnt <= '0;
      refresh  <= 1'b0;
    end else if (tick) begin
      if (hs_idle) begin
        refresh <= 1'b0;
        if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + 1'b1;
      end else begin
        refresh  <= (idle_cnt > IDLE_LIM);
        idle_cnt <= '0;
      end
    end
  end

  // R9: a refresh pulse is dropped at the following tick
  assert_refresh_one_period_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(refresh) && $past(tick)) |-> !refresh);

endmodule

// File: rtl/buck_sequencer.sv
module buck_sequencer
  import buck_seq_pkg::*;
#(
  parameter int STEP_TICKS = 32,
  parameter int SINK_STEPS = 4,
  parameter int HOLD_TICKS = 4096,
  parameter int IDLE_LIMIT = 8,
  localparam int SINK_W    = $clog2(SINK_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [1:0]        mode_code,
  input  logic              fb_above_ss,
  input  logic              fb_good,
  input  logic              izero,
  input  logic              hs_idle,
  output logic              hs_en,
  output logic              ls_en,
  output logic [1:0]        regime,
  output logic [SINK_W-1:0] sink_code
);

  seq_state_t        st;
  logic [1:0]        start_mode;
  logic              handover_done;
  logic              refresh;
  logic [SINK_W-1:0] ramp_code;
  logic              skip_sel;
  logic              ramp_run;
  logic              hand_active;
  logic              skip_armed;

  assign skip_sel    = mode_is_skip(mode_code);
  assign ramp_run    = (st == ST_PRECHG) || (st == ST_START) || (st == ST_FINAL);
  assign hand_active = (st == ST_START);
  assign skip_armed  = (st == ST_FINAL) && skip_sel && en;

  bsq_phase_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .tick          (tick),
    .mode_code     (mode_code),
    .fb_above_ss   (fb_above_ss),
    .handover_done (handover_done),
    .state         (st),
    .start_mode    (start_mode)
  );

  bsq_sink_ramp #(
    .STEP_TICKS (STEP_TICKS),
    .NUM_STEPS  (SINK_STEPS)
  ) u_ramp (
    .clk  (clk),
    .rst  (rst),
    .run  (ramp_run),
    .tick (tick),
    .code (ramp_code)
  );

  bsq_handover #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_hand (
    .clk     (clk),
    .rst     (rst),
    .active  (hand_active),
    .tick    (tick),
    .fb_good (fb_good),
    .done    (handover_done)
  );

  bsq_skip_refresh #(
    .IDLE_LIMIT (IDLE_LIMIT)
  ) u_refresh (
    .clk     (clk),
    .rst     (rst),
    .armed   (skip_armed),
    .tick    (tick),
    .hs_idle (hs_idle),
    .refresh (refresh)
  );

  logic              hs_d;
  logic              ls_d;
  regime_t           rg_d;
  logic [SINK_W-1:0] sk_d;
  regime_t           startup_rg;

  assign startup_rg = (start_mode == MODE_PLAIN) ? RG_PWM : RG_MONO;

  always_comb begin
    hs_d = 1'b0;
    ls_d = 1'b0;
    rg_d = RG_OFF;
    sk_d = '0;
    if (en) begin
      case (st)
        ST_HOLD: rg_d = startup_rg;
        ST_PRECHG: begin
          ls_d = 1'b1;
          rg_d = startup_rg;
          sk_d = ramp_code;
        end
        ST_START: begin
          hs_d = 1'b1;
          ls_d = 1'b1;
          rg_d = startup_rg;
          sk_d = ramp_code;
        end
        ST_FINAL: begin
          sk_d = ramp_code;
          if (skip_sel) begin
            rg_d = RG_SKIP;
            if (refresh) begin
              ls_d = 1'b1;
            end else begin
              hs_d = 1'b1;
              ls_d = !izero;
            end
          end else begin
            rg_d = RG_PWM;
            hs_d = 1'b1;
            ls_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_en     <= 1'b0;
      ls_en     <= 1'b0;
      regime    <= RG_OFF;
      sink_code <= '0;
    end else begin
      hs_en     <= hs_d;
      ls_en     <= ls_d;
      regime    <= rg_d;
      sink_code <= sk_d;
    end
  end

  // R3: the high side is never enabled without a low-side period just before
  assert_low_side_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> $past(ls_en));

  // R11: dropping enable clears every output at the next edge
  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hs_en && !ls_en && regime == RG_OFF && sink_code == '0));

  // R8: in skip, zero current releases the low side
  assert_zero_cross_R8: assert property (@(posedge clk) disable iff (rst)
    (en && st == ST_FINAL && skip_sel && !refresh && izero) |=> !ls_en);

  // R9: a refresh period keeps the high side off
  assert_refresh_hs_off_R9: assert property (@(posedge clk) disable iff (rst)
    (en && refresh && st == ST_FINAL && skip_sel) |=> (!hs_en && ls_en));

endmodule

// File: tb/buck_sequencer_test.sv
module buck_sequencer_test;

  logic       clk = 1'b0;
  logic       rst, en, tick, fb_above_ss, fb_good, izero, hs_idle;
  logic [1:0] mode_code;
  logic       hs_en, ls_en;
  logic [1:0] regime, sink_code;

  always #2.5 clk = ~clk;

  buck_sequencer uut (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .mode_code(mode_code),
    .fb_above_ss(fb_above_ss), .fb_good(fb_good), .izero(izero), .hs_idle(hs_idle),
    .hs_en(hs_en), .ls_en(ls_en), .regime(regime), .sink_code(sink_code)
  );

  typedef struct {
    logic [3:0] m;
    logic       hs;
    logic       ls;
    logic [1:0] rg;
    logic [1:0] sk;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;

  localparam logic [3:0] M_ALL = 4'b1111;
  localparam logic [3:0] M_HLR = 4'b1110;
  localparam logic [3:0] M_LR  = 4'b0110;
  localparam logic [3:0] M_HL  = 4'b1100;
  localparam logic [3:0] M_SK  = 4'b0001;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [3:0] m, input logic h, input logic l,
                            input logic [1:0] r, input logic [1:0] s, input string tag);
    exp_t e;
    e.m = m; e.hs = h; e.ls = l; e.rg = r; e.sk = s; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      exp_t e;
      logic bad;
      e = sbq.pop_front();
      bad = (e.m[3] && hs_en !== e.hs) || (e.m[2] && ls_en !== e.ls) ||
            (e.m[1] && regime !== e.rg) || (e.m[0] && sink_code !== e.sk);
      n_cmp++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s: got hs=%0b ls=%0b rg=%0d sk=%0d, expected hs=%0b ls=%0b rg=%0d sk=%0d (mask %b)",
                 e.tag, hs_en, ls_en, regime, sink_code, e.hs, e.ls, e.rg, e.sk, e.m);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; en = 0; tick = 1; mode_code = 2'b00;
    fb_above_ss = 0; fb_good = 0; izero = 0; hs_idle = 0;
    step(3);
    expect_out(M_ALL, 0, 0, 0, 0, "R12 reset outputs");
    rst = 0;
    step(2);

    // skip selected at enable: monotonic startup first
    en = 1; mode_code = 2'b10;
    step(10);
    expect_out(M_ALL, 0, 0, 2, 0, "R2 R1 hold with skip code");
    fb_above_ss = 1;                       // f = 0
    step(1);
    expect_out(M_ALL, 0, 0, 2, 0, "R2 still off before release edge");
    step(1);
    expect_out(M_ALL, 0, 1, 2, 0, "R3 first period low side only");
    step(1);                               // f = 3
    expect_out(M_HLR, 1, 1, 2, 0, "R1 monotonic PWM during startup");
    step(17);                              // f = 20
    expect_out(M_SK, 0, 0, 0, 0, "R5 sink code 0");
    step(20);                              // f = 40
    expect_out(M_SK, 0, 0, 0, 1, "R5 sink code 1");
    step(30);                              // f = 70
    expect_out(M_SK, 0, 0, 0, 2, "R5 sink code 2");
    step(30);                              // f = 100
    expect_out(M_SK, 0, 0, 0, 3, "R5 sink code 3");
    izero = 1;
    step(2);
    expect_out(M_HLR, 1, 1, 2, 3, "R6 skip withheld during startup");

    fb_good = 1;                           // g = 0
    step(4090);
    expect_out(M_ALL, 1, 1, 2, 3, "R6 still startup before 4096 ticks");
    step(15);
    expect_out(M_ALL, 1, 0, 3, 3, "R6 R8 skip after handover, zero cross");
    izero = 0;
    step(1);
    expect_out(M_HL, 1, 1, 0, 0, "R8 low side back on");

    // refresh: 8 idle ticks give none
    hs_idle = 1;
    step(8);
    hs_idle = 0;
    step(2);
    expect_out(M_HL, 1, 1, 0, 0, "R9 no refresh after 8 idle ticks");
    step(3);
    // 12 idle ticks give one refresh period
    hs_idle = 1;
    step(12);
    hs_idle = 0;
    step(1);
    expect_out(M_HL, 1, 1, 0, 0, "R9 before refresh period");
    step(1);
    expect_out(M_HLR, 0, 1, 3, 0, "R9 refresh period");
    step(1);
    expect_out(M_HL, 1, 1, 0, 0, "R9 refresh lasts one period");

    // live mode change after startup
    izero = 1;
    step(1);
    mode_code = 2'b00;
    step(1);
    expect_out(M_HLR, 1, 1, 1, 0, "R10 switch to forced PWM");
    mode_code = 2'b11;
    step(1);
    expect_out(M_HLR, 1, 0, 3, 0, "R10 R1 code 11 back to skip");

    // disable
    en = 0;
    step(1);
    expect_out(M_ALL, 0, 0, 0, 0, "R11 disable clears outputs");
    fb_above_ss = 0; fb_good = 0; izero = 0;
    step(5);

    // monotonic PWM code waits for feedback again
    en = 1; mode_code = 2'b01;
    step(6);
    expect_out(M_ALL, 0, 0, 2, 0, "R1 R2 code 01 holds");
    en = 0;
    step(2);

    // plain PWM starts at once
    en = 1; mode_code = 2'b00;
    step(2);
    expect_out(M_ALL, 0, 1, 1, 0, "R4 R3 plain start precharge");
    step(1);
    expect_out(M_HLR, 1, 1, 1, 0, "R7 forced PWM final");
    step(37);
    expect_out(M_SK, 0, 0, 0, 1, "R11 R5 ramp restarted from 0");
    izero = 1;
    step(1);
    expect_out(M_HLR, 1, 1, 1, 0, "R7 zero cross ignored in forced PWM");

    step(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule